// File: doc/BRIEF.md
# Rotating-Pattern Memory Test Controller

This block is a hardware test engine for a byte-wide memory space of 128 locations. A caller gives it a 7-bit first address, a 7-bit last address and an 8-bit seed byte, then pulses `start`. The engine then runs eight passes over the range. Each pass uses one rotation of the seed. A pass first writes the pass pattern to every address of the range in ascending order. It then reads every address back in the same order and compares each byte with the pattern.

The engine drives a simple synchronous memory port that returns read data one cycle after a read request. It also decodes each access address into a select for an internal region or for one of two external banks. When the run ends, the engine pulses `done`. It flags a clean run with `pass`. If a read-back differs from the pattern, it stops at once and holds `fail`, together with the failing address, the expected byte and the byte that came back.

Top module: `memtest_engine`

## Requirements
- R1: A `start` pulse seen while idle with `start_addr` <= `end_addr` begins a run. From the next cycle `busy` is high, the first access is a write to `start_addr`, and `fail`, `fail_addr`, `fail_exp` and `fail_act` read zero.
- R2: A `start` pulse seen while idle with `start_addr` > `end_addr` is rejected. `busy` stays low, no memory access is made, and `done`, `pass`, `fail` and the three failure fields keep their values.
- R3: Pass k, for k = 0 to 7 in that order, uses the seed rotated left by k bit positions. Bit 7 wraps into bit 0.
- R4: In each pass, one write per cycle goes to every address from `start_addr` up to `end_addr` in ascending order. After that, reads go to the same addresses in the same order. No read of a pass comes before that pass's last write, and no access leaves the range.
- R5: Read data is taken on the cycle after `mem_re`, and each read takes two cycles. With the accepting edge counted as edge 0, a clean run over N addresses raises `done` in the cycle after edge 24·N.
- R6: During an access, `sel_int` is high for addresses 0x00–0x3f. For addresses 0x40–0x7f, address bit 5 picks the external bank: `sel_ext[0]` when the bit is 0 and `sel_ext[1]` when it is 1. Exactly one select is high during an access, and none is high when there is no access.
- R7: A `start` pulse seen while `busy` is high has no effect on the running test or on its access sequence.
- R8: On the first read-back that differs from the pass pattern, the engine makes no further access. `done` pulses for one cycle with `pass` low. `fail` rises and holds the failing address, the expected byte and the byte read until the next accepted start or reset.
- R9: After eight clean passes, `done` and `pass` are high together for exactly one cycle, with `fail` low. The engine is then idle with `busy` low.
- R10: A range of one address (`start_addr` = `end_addr`) is legal and runs all eight passes, so `done` arrives after 24 cycles.
- R11: Asserting `rst_n` low at any time makes the engine idle at once, with no access and all of `busy`, `done`, `pass`, `fail` and the failure fields at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, sampled while idle |
| start_addr | input | 7 | First address of the range |
| end_addr | input | 7 | Last address of the range |
| seed | input | 8 | Pattern for pass 0 |
| mem_addr | output | 7 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data expected one cycle later |
| mem_rdata | input | 8 | Read data |
| sel_int | output | 1 | Internal region select |
| sel_ext | output | 2 | External bank selects |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | High with `done` after a clean run |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | 7 | Address of the first mismatch |
| fail_exp | output | 8 | Pattern expected there |
| fail_act | output | 8 | Byte read back there |

## Verification
The assertions assume that `mem_rdata` carries known data one cycle after every `mem_re`. They also assume that `start_addr`, `end_addr` and `seed` are steady at the edge where `start` is sampled. The bench's memory model honours that latency. It starts with zeroed contents, and its stuck-bit faults act only on read data, so a correct engine always gets back what it wrote except where a fault is placed. Inputs change only on falling edges, and random ranges are kept to at most 16 addresses within 0x00–0x7f so that each run stays short.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_CHECK = 2'd3
  } mt_state_e;

  function automatic logic [7:0] rotl1_byte(input logic [7:0] v);
    return {v[6:0], v[7]};
  endfunction

endpackage

// File: rtl/memtest_pattern.sv
module memtest_pattern #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [DATA_W-1:0] seed,
  output logic [DATA_W-1:0] pattern,
  output logic              last_pass
);
  localparam int NUM_PASSES = DATA_W;
  localparam int PASS_W     = $clog2(NUM_PASSES);

  logic [DATA_W-1:0] pat_q, pat_d;
  logic [PASS_W-1:0] idx_q, idx_d;
  logic              pat_en;

  always_comb begin
    pat_en = load | advance;
    if (load) begin
      pat_d = seed;
      idx_d = '0;
    end else begin
      pat_d = {pat_q[DATA_W-2:0], pat_q[DATA_W-1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      idx_q <= '0;
    end else if (pat_en) begin
      pat_q <= pat_d;
      idx_q <= idx_d;
    end
  end

  assign pattern   = pat_q;
  assign last_pass = (idx_q == PASS_W'(NUM_PASSES - 1));

  // R3: a rotation never changes how many ones the pattern holds
  p_rotation_keeps_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($countones(pat_q) == $countones($past(pat_q))));

endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              mismatch,
  input  logic              last_pass,
  output logic              busy,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic              cmp_en,
  output logic              load,
  output logic              advance,
  output logic              finish_ok
);
  mt_state_e         state_q, state_d;
  logic [ADDR_W-1:0] cur_q, cur_d, lo_q, hi_q;
  logic              cur_en, at_end;

  assign at_end = (cur_q == hi_q);

  always_comb begin
    state_d   = state_q;
    cur_d     = cur_q;
    cur_en    = 1'b0;
    load      = 1'b0;
    advance   = 1'b0;
    finish_ok = 1'b0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    cmp_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && (start_addr <= end_addr)) begin
          load    = 1'b1;
          cur_d   = start_addr;
          cur_en  = 1'b1;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        mem_we = 1'b1;
        cur_en = 1'b1;
        if (at_end) begin
          cur_d   = lo_q;
          state_d = ST_READ;
        end else begin
          cur_d = cur_q + 1'b1;
        end
      end
      ST_READ: begin
        mem_re  = 1'b1;
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        cmp_en = 1'b1;
        if (mismatch) begin
          state_d = ST_IDLE;
        end else if (at_end) begin
          if (last_pass) begin
            finish_ok = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            advance = 1'b1;
            cur_d   = lo_q;
            cur_en  = 1'b1;
            state_d = ST_WRITE;
          end
        end else begin
          cur_d   = cur_q + 1'b1;
          cur_en  = 1'b1;
          state_d = ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cur_en) cur_q <= cur_d;
      if (load) begin
        lo_q <= start_addr;
        hi_q <= end_addr;
      end
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign acc_addr = cur_q;

  // R4: every access falls inside the latched range
  p_access_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> ((cur_q >= lo_q) && (cur_q <= hi_q)));

  // R7: a start seen mid-run leaves the range untouched
  p_range_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lo_q) && $stable(hi_q)));

  // R2: an inverted range never launches a run
  p_reject_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (start_addr > end_addr)) |=> !busy);

endmodule

// File: rtl/memtest_check.sv
module memtest_check #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              clear,
  input  logic              finish_ok,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] expected,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);
  logic              done_q, pass_q, fail_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [DATA_W-1:0] fexp_q, fact_q;
  logic              rec_en;

  assign mismatch = cmp_en && (rdata != expected);
  assign rec_en   = clear | mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= finish_ok | mismatch;
      pass_q <= finish_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fact_q  <= '0;
    end else if (rec_en) begin
      fail_q  <= mismatch;
      faddr_q <= clear ? '0 : acc_addr;
      fexp_q  <= clear ? '0 : expected;
      fact_q  <= clear ? '0 : rdata;
    end
  end

  assign done      = done_q;
  assign pass      = pass_q;
  assign fail      = fail_q;
  assign fail_addr = faddr_q;
  assign fail_exp  = fexp_q;
  assign fail_act  = fact_q;

  // R8: a failure holds until a new run is accepted
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear) |=> fail_q);

  // R9: the end-of-run pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: pass only appears with done and without fail
  p_pass_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> (done_q && !fail_q));

endmodule

// File: rtl/memtest_decode.sv
module memtest_decode #(
  parameter int ADDR_W   = 7,
  parameter int INT_SPAN = 64,
  parameter int BANK_BIT = 5
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_int,
  output logic [1:0]        sel_ext
);
  localparam logic [ADDR_W-1:0] INT_TOP = ADDR_W'(INT_SPAN);
  localparam int NUM_BANKS = 2;

  logic in_int;

  assign in_int  = (addr < INT_TOP);
  assign sel_int = active & in_int;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel_ext[b] = active & ~in_int & (addr[BANK_BIT] == b[0]);
  end

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int INT_SPAN = 64,
  parameter int BANK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [DATA_W-1:0] seed,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sel_int,
  output logic [1:0]        sel_ext,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);
  logic              mismatch, last_pass, cmp_en, load, advance, finish_ok;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] pattern;

  memtest_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_addr(start_addr), .end_addr(end_addr),
    .mismatch(mismatch), .last_pass(last_pass),
    .busy(busy), .acc_addr(acc_addr),
    .mem_we(mem_we), .mem_re(mem_re), .cmp_en(cmp_en),
    .load(load), .advance(advance), .finish_ok(finish_ok)
  );

  memtest_pattern #(.DATA_W(DATA_W)) pat_i (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .seed(seed), .pattern(pattern), .last_pass(last_pass)
  );

  memtest_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .clear(load),
    .finish_ok(finish_ok), .acc_addr(acc_addr), .expected(pattern),
    .rdata(mem_rdata), .mismatch(mismatch),
    .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  memtest_decode #(.ADDR_W(ADDR_W), .INT_SPAN(INT_SPAN), .BANK_BIT(BANK_BIT)) dec_i (
    .active(mem_we | mem_re), .addr(acc_addr),
    .sel_int(sel_int), .sel_ext(sel_ext)
  );

  assign mem_addr  = acc_addr;
  assign mem_wdata = pattern;

  // R5: a compare cycle always follows a read request
  p_compare_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> $past(mem_re));

  // R6: exactly one region select during an access
  p_one_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> ($countones({sel_int, sel_ext}) == 1));

  // R6: no select without an access
  p_no_select_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we || mem_re) |-> !(sel_int || (|sel_ext)));

endmodule

// File: tb/memtest_engine_tb_top.sv
module memtest_engine_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [6:0] start_addr, end_addr;
  logic [7:0] seed;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_we, mem_re, sel_int;
  logic [1:0] sel_ext;
  logic       busy, done, pass, fail;
  logic [6:0] fail_addr;
  logic [7:0] fail_exp, fail_act;

  always #10 clk = ~clk;

  memtest_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .start_addr(start_addr), .end_addr(end_addr), .seed(seed),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata),
    .sel_int(sel_int), .sel_ext(sel_ext),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // memory model with read-side stuck-bit faults
  logic [7:0] mem [0:127];
  bit         f_on;
  int         f_addr;   // negative: fault on every address
  logic [7:0] f_m0, f_m1;

  function automatic bit fault_hit(input int a);
    return f_on && (f_addr < 0 || f_addr == a);
  endfunction

  function automatic logic [7:0] apply_fault(input int a, input logic [7:0] v);
    return fault_hit(a) ? ((v & ~f_m0) | f_m1) : v;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= apply_fault(int'(mem_addr), mem[mem_addr]);
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_all();
  end

  function automatic logic [7:0] rotl(input logic [7:0] v, input int k);
    logic [15:0] t;
    t = {v, v} << k;
    return t[15:8];
  endfunction

  // expected access sequence and outcome
  bit         ex_we   [0:2047];
  logic [6:0] ex_addr [0:2047];
  logic [7:0] ex_dat  [0:2047];
  int         nops, cyc;
  bit         x_fail;
  logic [6:0] x_addr;
  logic [7:0] x_exp, x_act;

  task automatic gen(input int s, input int e, input logic [7:0] sd);
    nops = 0; cyc = 0; x_fail = 1'b0; x_addr = '0; x_exp = '0; x_act = '0;
    for (int p = 0; p < 8; p++) begin
      logic [7:0] pat;
      pat = rotl(sd, p);
      for (int a = s; a <= e; a++) begin
        ex_we[nops] = 1'b1; ex_addr[nops] = a[6:0]; ex_dat[nops] = pat;
        nops++; cyc += 1;
      end
      for (int a = s; a <= e; a++) begin
        logic [7:0] got;
        ex_we[nops] = 1'b0; ex_addr[nops] = a[6:0]; ex_dat[nops] = pat;
        nops++; cyc += 2;
        got = apply_fault(a, pat);
        if (got != pat) begin
          x_fail = 1'b1; x_addr = a[6:0]; x_exp = pat; x_act = got;
          return;
        end
      end
    end
  endtask

  task automatic check_decode(input string tag);
    logic       ein;
    logic [1:0] eext;
    bit         acc;
    acc  = mem_we || mem_re;
    ein  = acc && (mem_addr < 7'h40);
    eext = 2'b00;
    if (acc && !ein) eext[mem_addr[5]] = 1'b1;
    chk(sel_int == ein && sel_ext == eext, tag, {29'd0, sel_int, sel_ext}, {29'd0, ein, eext});
  endtask

  task automatic run_test(input int s, input int e, input logic [7:0] sd, input bit mid_start);
    int op;
    gen(s, e, sd);
    @(negedge clk);
    start_addr = s[6:0]; end_addr = e[6:0]; seed = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op = 0;
    for (int n = 1; n <= cyc + 1; n++) begin
      if (n > 1) @(negedge clk);
      if (mid_start && n == 3) begin
        // R7: a conflicting request while busy
        start_addr = 7'h00; end_addr = 7'h7f; seed = ~sd; start = 1'b1;
      end
      if (mid_start && n == 4) start = 1'b0;
      if (n == 1) begin
        chk(busy == 1'b1, "R1 busy after accept", {31'd0, busy}, 32'd1);
        chk(!fail && fail_addr == 0 && fail_exp == 0 && fail_act == 0,
            "R1 status cleared", {fail, fail_addr, fail_exp, fail_act}, 32'd0);
      end
      if (n <= cyc) begin
        check_decode("R6 select");
        if (done) chk(1'b0, "R5 done too early", 32'd1, 32'd0);
        if (mem_we || mem_re) begin
          if (op >= nops)
            chk(1'b0, "R4 extra access", {25'd0, mem_addr}, 32'd0);
          else if (ex_we[op])
            chk(mem_we && mem_addr == ex_addr[op] && mem_wdata == ex_dat[op],
                "R3 R4 write", {mem_we, 8'd0, mem_addr, 8'd0, mem_wdata},
                {1'b1, 8'd0, ex_addr[op], 8'd0, ex_dat[op]});
          else
            chk(mem_re && mem_addr == ex_addr[op], "R4 read",
                {mem_re, 16'd0, mem_addr}, {1'b1, 16'd0, ex_addr[op]});
          op++;
        end
      end else begin
        if (x_fail) begin
          chk(done && fail && !pass, "R8 done with fail", {done, fail, pass}, 3'b110);
          chk(fail_addr == x_addr, "R8 fail_addr", {25'd0, fail_addr}, {25'd0, x_addr});
          chk(fail_exp == x_exp, "R8 fail_exp", {24'd0, fail_exp}, {24'd0, x_exp});
          chk(fail_act == x_act, "R8 fail_act", {24'd0, fail_act}, {24'd0, x_act});
        end else begin
          chk(done && pass && !fail, "R5 R9 clean finish", {done, pass, fail}, 3'b110);
        end
        chk(op == nops, "R4 access count", op, nops);
      end
    end
    @(negedge clk);
    chk(!done && !pass && !busy && !mem_we && !mem_re, "R8 R9 pulse then idle",
        {done, pass, busy, mem_we, mem_re}, 5'd0);
    chk(fail == x_fail, "R8 fail level", {31'd0, fail}, {31'd0, x_fail});
  endtask

  initial begin
    logic [6:0] o_addr;
    logic [7:0] o_exp, o_act;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    f_on = 1'b0; f_addr = -1; f_m0 = 8'h00; f_m1 = 8'h00;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; end_addr = '0; seed = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !mem_we && !mem_re, "R11 reset state",
        {busy, done, pass, fail, mem_we, mem_re}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && fail_addr == 0 && fail_exp == 0 && fail_act == 0 && !sel_int && sel_ext == 0,
        "R11 idle after release", {busy, fail_addr, fail_exp, fail_act}, 32'd0);

    run_test(0, 127, 8'h81, 1'b0);           // R6 R9 full space
    run_test(8'h3f, 8'h3f, 8'h01, 1'b0);     // R10 single address
    run_test(8'h3e, 8'h41, 8'ha5, 1'b0);     // R6 region boundary
    run_test(8'h5e, 8'h62, 8'h3c, 1'b0);     // R6 bank boundary
    run_test(8'h10, 8'h18, 8'h96, 1'b1);     // R7

    // R8: stuck-at-0 on one cell, bit 4; seed 0x01 first sets it in pass 4
    f_on = 1'b1; f_addr = 8'h62; f_m0 = 8'h10; f_m1 = 8'h00;
    run_test(8'h60, 8'h6f, 8'h01, 1'b0);
    f_on = 1'b0;

    // R2: inverted range leaves status alone
    o_addr = fail_addr; o_exp = fail_exp; o_act = fail_act;
    @(negedge clk);
    start_addr = 7'h20; end_addr = 7'h10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 8; n++) begin
      chk(!busy && !mem_we && !mem_re && !done && fail && fail_addr == o_addr &&
          fail_exp == o_exp && fail_act == o_act, "R2 rejected request",
          {busy, mem_we, mem_re, done, fail}, 5'b00001);
      @(negedge clk);
    end

    // R11: asynchronous reset clears a held failure
    rst_n = 1'b0;
    #2;
    chk(!fail && fail_addr == 0 && fail_exp == 0 && fail_act == 0 && !busy,
        "R11 reset clears status", {fail, fail_addr, fail_exp, fail_act}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: data line stuck at 1 on every address; seed 0xfe keeps bit 7 set until pass 7
    f_on = 1'b1; f_addr = -1; f_m0 = 8'h00; f_m1 = 8'h80;
    run_test(8'h05, 8'h0c, 8'hfe, 1'b0);
    // R9: the same fault stays hidden when every pattern has bit 7 set
    run_test(8'h05, 8'h0c, 8'hff, 1'b0);
    f_on = 1'b0;

    for (int i = 0; i < 24; i++) begin
      int s, e, kind;
      s = int'($urandom % 128);
      e = s + int'($urandom % 16);
      if (e > 127) e = 127;
      kind = int'($urandom % 3);
      f_on = (kind != 0);
      if (kind == 1) begin
        f_addr = s + int'($urandom % (e - s + 1));
        f_m0 = 8'h01 << ($urandom % 8); f_m1 = 8'h00;
      end else begin
        f_addr = -1;
        f_m0 = 8'h00; f_m1 = 8'h01 << ($urandom % 8);
      end
      run_test(s, e, 8'($urandom), 1'b0);
    end
    f_on = 1'b0;
    finish_all();
  end

endmodule